// File: doc/BRIEF.md
# Increment Instruction Encoding Decoder

This block inspects up to three bytes at the head of an instruction stream and decides whether they encode an increment by one. The bytes can be an optional register-extension prefix, an opcode byte and an operand-selector (ModRM) byte. A mode input selects the 64-bit rules or the legacy/compatibility rules. A second input gives the default operand size.

For a valid increment, the block reports the operand width, the destination register number or a memory-operand flag, the encoded length, and whether a byte register code means one of the four legacy high-byte registers. It also flags the one-byte register form when it shows up in 64-bit mode, where that form cannot be encoded. Anything else is reported as "not increment", with every field cleared.

The result is registered once. It appears on the outputs one clock after a valid input is sampled.

Top module: `incr_decode`

## Requirements
- R1: A sampled `in_valid` gives `out_valid` high exactly one cycle later. When `in_valid` was low, all outputs are zero in the next cycle. After synchronous reset, all outputs are zero.
- R2: The width code is 0 for byte, 1 for word, 2 for doubleword and 3 for quadword. Opcode 0xFE with ModRM bits [5:3] = 0 is a byte increment of length 2 when no prefix is present.
- R3: Opcode 0xFF with ModRM bits [5:3] = 0 is an increment whose width is word when `op16` = 1 and doubleword when `op16` = 0.
- R4: In 64-bit mode, a prefix byte 0x48–0x4F (bit 3 set) before 0xFF /0 gives a quadword increment of length 3. In legacy mode, the quadword width is never reported.
- R5: In legacy mode, a first byte of 0x40–0x47 is a one-byte increment. Its length is 1, its destination register is bits [2:0], and its width follows `op16`.
- R6: In 64-bit mode, a first byte of 0x40–0x4F is a prefix and is never an increment on its own. If the first byte is 0x40–0x47 and no valid increment follows, `out_bad_mode` = 1.
- R7: A prefix adds bit 0 of the prefix byte as bit 3 of the destination register, so registers 8–15 can be reached.
- R8: `out_hbyte` = 1 only for a byte-width register increment with register code 4–7 and no prefix. When any prefix is present, the same codes name the low bytes of SP, BP, SI and DI, and `out_hbyte` = 0.
- R9: If ModRM bits [7:6] are not 3, `out_mem` = 1 and `out_reg` = 0. If they are 3, the destination is register `out_reg`.
- R10: Opcode 0xFE or 0xFF with ModRM bits [5:3] ≠ 0, and any other opcode, give `out_is_inc` = 0 with width, register, length and memory fields all zero.
- R11: `out_is_inc` and `out_bad_mode` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte window is present this cycle |
| in_bytes | input | 24 | Stream bytes, first byte in [7:0] |
| long_mode | input | 1 | 1 = 64-bit rules, 0 = legacy/compatibility |
| op16 | input | 1 | Default operand size is 16 bits |
| out_valid | output | 1 | Result present |
| out_is_inc | output | 1 | Bytes form a valid increment |
| out_bad_mode | output | 1 | One-byte form seen where it cannot be encoded |
| out_width | output | 2 | Operand width code |
| out_mem | output | 1 | Destination is memory |
| out_reg | output | 4 | Destination register number |
| out_len | output | 2 | Encoded length in bytes (1–3) |
| out_hbyte | output | 1 | Byte register code names a high-byte register |

## Verification
Every result is due one cycle after the edge that samples `in_valid`, and all fields arrive in that same cycle. The bench drives its inputs on the falling edge. A behavioural model computes the expected fields from those inputs, and the bench compares them with the outputs shortly after the next rising edge. Because of this, a result is never compared against the inputs of the following cycle. Idle cycles are compared the same way, against all-zero fields.

// File: rtl/incr_decode_pkg.sv
// Package: shared widths, opcode constants and the result record of the
// increment decoder. Assumes byte-oriented streams, first byte lowest.
package incr_decode_pkg;
    parameter int BYTE_W  = 8;
    parameter int NBYTES  = 3;
    localparam int STREAM_W = BYTE_W * NBYTES;
    localparam int REG_W    = 4;
    localparam int LEN_W    = 2;

    localparam logic [BYTE_W-1:0] OPC_INC8   = 8'hFE;
    localparam logic [BYTE_W-1:0] OPC_INCV   = 8'hFF;
    localparam logic [4:0]        SHORT_HI5  = 5'b01000; // 0x40..0x47
    localparam logic [3:0]        PFX_HI4    = 4'h4;     // 0x40..0x4F

    typedef enum logic [1:0] {
        WD_BYTE  = 2'd0,
        WD_WORD  = 2'd1,
        WD_DWORD = 2'd2,
        WD_QWORD = 2'd3
    } incw_t;

    typedef struct packed {
        logic             is_inc;
        logic             bad_mode;
        incw_t            width;
        logic             mem;
        logic [REG_W-1:0] dreg;
        logic [LEN_W-1:0] len;
        logic             hbyte;
    } incres_t;
endpackage

// File: rtl/incr_prefix_split.sv
// Module: separates an optional register-extension prefix from the opcode
// and ModRM bytes. Assumes the prefix is recognised only in 64-bit mode.
module incr_prefix_split
    import incr_decode_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int NB = NBYTES
) (
    input  logic [BW*NB-1:0] stream,
    input  logic             long_mode,
    output logic             pfx_seen,
    output logic             pfx_w,
    output logic             pfx_b,
    output logic [BW-1:0]    first,
    output logic [BW-1:0]    opc,
    output logic [BW-1:0]    modrm
);
    logic [BW-1:0] byt [NB];

    // Slice the stream into bytes.
    for (genvar i = 0; i < NB; i++) begin : g_slice
        assign byt[i] = stream[i*BW +: BW];
    end

    // Detect the prefix and shift the opcode window past it.
    always_comb begin
        first    = byt[0];
        pfx_seen = long_mode && (byt[0][7:4] == PFX_HI4);
        pfx_w    = pfx_seen && byt[0][3];
        pfx_b    = pfx_seen && byt[0][0];
        opc      = pfx_seen ? byt[1] : byt[0];
        modrm    = pfx_seen ? byt[2] : byt[1];
    end
endmodule

// File: rtl/incr_form_classify.sv
// Module: classifies the opcode/ModRM pair as an increment form and fills
// the result record. Assumes prefix splitting is already done.
module incr_form_classify
    import incr_decode_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic          long_mode,
    input  logic          op16,
    input  logic          pfx_seen,
    input  logic          pfx_w,
    input  logic          pfx_b,
    input  logic [BW-1:0] first,
    input  logic [BW-1:0] opc,
    input  logic [BW-1:0] modrm,
    output incres_t       res
);
    logic [1:0] mod_f;
    logic [2:0] ext_f;
    logic [2:0] rm_f;
    logic       short_form;
    logic       rm_form;
    incw_t      vsize;

    // Split ModRM fields and recognise the candidate forms.
    always_comb begin
        mod_f      = modrm[7:6];
        ext_f      = modrm[5:3];
        rm_f       = modrm[2:0];
        short_form = (first[7:3] == SHORT_HI5);
        rm_form    = ((opc == OPC_INC8) || (opc == OPC_INCV)) && (ext_f == 3'd0);
        vsize      = op16 ? WD_WORD : WD_DWORD;
    end

    // Build the result record for the recognised form.
    always_comb begin
        res = '0;
        if (!long_mode && short_form) begin
            res.is_inc = 1'b1;
            res.width  = vsize;
            res.dreg   = {1'b0, first[2:0]};
            res.len    = 2'd1;
        end else if (rm_form) begin
            res.is_inc = 1'b1;
            if (opc == OPC_INC8)  res.width = WD_BYTE;
            else if (pfx_w)       res.width = WD_QWORD;
            else                  res.width = vsize;
            res.len = pfx_seen ? 2'd3 : 2'd2;
            if (mod_f != 2'b11) begin
                res.mem = 1'b1;
            end else begin
                res.dreg  = {pfx_b, rm_f};
                res.hbyte = (opc == OPC_INC8) && !pfx_seen && rm_f[2];
            end
        end else if (long_mode && short_form) begin
            res.bad_mode = 1'b1;
        end
    end
endmodule

// File: rtl/incr_result_reg.sv
// Module: output register stage; clears the record on idle cycles.
// Assumes synchronous active-low reset.
module incr_result_reg
    import incr_decode_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    in_valid,
    input  incres_t d,
    output logic    q_valid,
    output incres_t q
);
    // Register valid and the record, zeroed when idle or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q       <= '0;
        end else begin
            q_valid <= in_valid;
            q       <= in_valid ? d : '0;
        end
    end
endmodule

// File: rtl/incr_decode.sv
// Module: top of the increment decoder. One registered stage; the result
// for a sampled byte window appears one clock later.
module incr_decode
    import incr_decode_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [STREAM_W-1:0] in_bytes,
    input  logic                long_mode,
    input  logic                op16,
    output logic                out_valid,
    output logic                out_is_inc,
    output logic                out_bad_mode,
    output logic [1:0]          out_width,
    output logic                out_mem,
    output logic [REG_W-1:0]    out_reg,
    output logic [LEN_W-1:0]    out_len,
    output logic                out_hbyte
);
    logic              pfx_seen, pfx_w, pfx_b;
    logic [BYTE_W-1:0] first, opc, modrm;
    incres_t           res_c, res_q;

    incr_prefix_split #(.BW(BYTE_W), .NB(NBYTES)) u_split (
        .stream(in_bytes), .long_mode(long_mode),
        .pfx_seen(pfx_seen), .pfx_w(pfx_w), .pfx_b(pfx_b),
        .first(first), .opc(opc), .modrm(modrm)
    );

    incr_form_classify #(.BW(BYTE_W)) u_cls (
        .long_mode(long_mode), .op16(op16),
        .pfx_seen(pfx_seen), .pfx_w(pfx_w), .pfx_b(pfx_b),
        .first(first), .opc(opc), .modrm(modrm), .res(res_c)
    );

    incr_result_reg u_reg (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .d(res_c), .q_valid(out_valid), .q(res_q)
    );

    // Unpack the registered record onto the ports.
    always_comb begin
        out_is_inc   = res_q.is_inc;
        out_bad_mode = res_q.bad_mode;
        out_width    = res_q.width;
        out_mem      = res_q.mem;
        out_reg      = res_q.dreg;
        out_len      = res_q.len;
        out_hbyte    = res_q.hbyte;
    end
endmodule

// File: rtl/incr_decode_chk.sv
// Checker: temporal properties on the decoder ports, bound to the top.
module incr_decode_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [23:0] in_bytes,
    input logic        long_mode,
    input logic        op16,
    input logic        out_valid,
    input logic        out_is_inc,
    input logic        out_bad_mode,
    input logic [1:0]  out_width,
    input logic        out_mem,
    input logic [3:0]  out_reg,
    input logic [1:0]  out_len,
    input logic        out_hbyte
);
    p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_is_inc && !out_bad_mode && out_len == 2'd0));
    p_quad_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_is_inc && out_width == 2'd3) |-> ($past(long_mode) && out_len == 2'd3));
    p_short_legacy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_is_inc && out_len == 2'd1) |-> (!$past(long_mode) && !out_mem));
    p_mem_noreg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_mem |-> (out_reg == 4'd0 && out_is_inc && !out_hbyte));
    p_noinc_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_inc) |-> (out_width == 2'd0 && out_len == 2'd0 && out_reg == 4'd0 && !out_mem));
    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_is_inc && out_bad_mode));
endmodule

bind incr_decode incr_decode_chk u_chk (.*);

// File: tb/tb_incr_decode.sv
module tb_incr_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_bytes = '0;
    logic        long_mode = 1'b0;
    logic        op16 = 1'b0;
    logic        out_valid, out_is_inc, out_bad_mode, out_mem, out_hbyte;
    logic [1:0]  out_width, out_len;
    logic [3:0]  out_reg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    incr_decode dut (.*);

    // Reference model: returns {inc,bad,width[2],mem,reg[4],len[2],hb}
    function automatic logic [12:0] model(input logic [7:0] a, b, c,
                                          input bit lm, input bit o16, input bit v);
        int inc = 0, bad = 0, w = 0, mem = 0, rg = 0, ln = 0, hb = 0;
        int has_pfx;
        logic [7:0] op, mr;
        if (!v) return '0;
        has_pfx = (lm && a >= 8'h40 && a <= 8'h4F) ? 1 : 0;
        op = has_pfx ? b : a;
        mr = has_pfx ? c : b;
        if (!lm && a >= 8'h40 && a <= 8'h47) begin
            inc = 1; w = o16 ? 1 : 2; rg = a - 8'h40; ln = 1;
        end else if ((op == 8'hFE || op == 8'hFF) && ((mr >> 3) % 8) == 0) begin
            inc = 1;
            ln = has_pfx ? 3 : 2;
            if (op == 8'hFE) w = 0;
            else if (has_pfx && a[3]) w = 3;
            else w = o16 ? 1 : 2;
            if (mr < 8'hC0) mem = 1;
            else begin
                rg = (mr % 8) + ((has_pfx && a[0]) ? 8 : 0);
                hb = (op == 8'hFE && !has_pfx && (mr % 8) >= 4) ? 1 : 0;
            end
        end else if (lm && a >= 8'h40 && a <= 8'h47) begin
            bad = 1;
        end
        return {inc[0], bad[0], w[1:0], mem[0], rg[3:0], ln[1:0], hb[0]};
    endfunction

    function automatic logic [12:0] actual();
        return {out_is_inc, out_bad_mode, out_width, out_mem, out_reg, out_len, out_hbyte};
    endfunction

    task automatic compare(input logic [12:0] exp, input bit expv, input string tag);
        checks++;
        if (actual() !== exp || out_valid !== expv) begin
            errors++;
            $display("FAIL %s: got valid=%0b fields=%h, expected valid=%0b fields=%h",
                     tag, out_valid, actual(), expv, exp);
        end
    endtask

    // Drive one window at the falling edge, compare one cycle later.
    task automatic step(input logic [7:0] a, b, c, input bit lm, o16, v, input string tag);
        logic [12:0] exp;
        @(negedge clk);
        in_bytes = {c, b, a}; long_mode = lm; op16 = o16; in_valid = v;
        exp = model(a, b, c, lm, o16, v);
        @(posedge clk);
        #1;
        compare(exp, v, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare('0, 1'b0, "R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        step(8'hFE, 8'hC1, 8'h00, 0, 0, 1, "R2 legacy byte");
        step(8'hFE, 8'hC3, 8'h00, 1, 0, 1, "R2 64 byte");
        step(8'hFF, 8'hC0, 8'h00, 0, 1, 1, "R3 word");
        step(8'hFF, 8'hC0, 8'h00, 0, 0, 1, "R3 dword");
        step(8'h00, 8'h00, 8'h00, 0, 0, 0, "R1 idle");
        step(8'h48, 8'hFF, 8'hC2, 1, 1, 1, "R4 quad");
        step(8'h48, 8'hFF, 8'hC2, 0, 0, 1, "R4 legacy no quad");
        step(8'h43, 8'h00, 8'h00, 0, 1, 1, "R5 short word");
        step(8'h47, 8'h00, 8'h00, 0, 0, 1, "R5 short dword");
        step(8'h43, 8'h00, 8'h00, 1, 0, 1, "R6 bad mode");
        step(8'h4C, 8'h00, 8'h00, 1, 0, 1, "R6 prefix only");
        step(8'h41, 8'hFF, 8'hC5, 1, 0, 1, "R7 ext reg");
        step(8'hFE, 8'hC6, 8'h00, 1, 0, 1, "R8 high byte");
        step(8'h40, 8'hFE, 8'hC6, 1, 0, 1, "R8 low byte w/ prefix");
        step(8'hFF, 8'h00, 8'h00, 0, 0, 1, "R9 mem");
        step(8'h49, 8'hFF, 8'h80, 1, 0, 1, "R9 mem prefix");
        step(8'hFE, 8'hC8, 8'h00, 0, 0, 1, "R10 ext field");
        step(8'hFF, 8'hF0, 8'h00, 1, 0, 1, "R10 other ext");
        step(8'h90, 8'h00, 8'h00, 0, 0, 1, "R10 other opcode");
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a, b, c;
            int sel = $urandom_range(0, 3);
            a = (sel == 0) ? 8'($urandom) : (sel == 1) ? 8'(8'h40 + $urandom_range(0, 15))
              : (sel == 2) ? 8'hFE : 8'hFF;
            b = ($urandom_range(0, 1) == 1) ? 8'($urandom) : ($urandom_range(0, 1) == 1 ? 8'hFE : 8'hFF);
            c = 8'($urandom) & ($urandom_range(0, 1) == 1 ? 8'hC7 : 8'hFF);
            step(a, b, c, 1'($urandom), 1'($urandom), ($urandom_range(0, 7) != 0), "R11 random");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule